// File: doc/BRIEF.md
# Single-Cycle Word-Instruction Core

This block runs a small 32-bit load/store instruction set and completes every instruction in one clock cycle. Each instruction is one 32-bit word, and its fields sit at the same bit positions in every format. Each cycle the core presents the program counter on an instruction address port and decodes the word that comes back. It then reads two registers from a 32-entry register file and computes a result with a small ALU or an address adder. Within the same cycle it either writes the result back, issues a data-memory access, or redirects the program counter.

Instruction memory and data memory are external and combinational-read, and a data-memory write takes effect on the clock edge. The instructions decoded are add, sub, slt, addi, slti, lw, sw, lui, beq, bne and j. Any other opcode, or any other function code under the register opcode, does nothing except advance the program counter. A branch offset counts words, and its target is computed from the branch's own address.

Top module: `tiny_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, the program counter becomes 0 at that edge, so `imem_addr` reads 0 in the next cycle.
- R2: After any instruction that is not a taken branch or a jump, `imem_addr` advances by 4 at the next edge.
- R3: Opcode 0 decodes by function code in bits 5:0: 32 is add, 34 is sub and 42 is signed set-less-than, which writes 1 or 0. The fields are: first source in bits 25:21, second source in bits 20:16, destination in bits 15:11.
- R4: Opcode 8 (addi) and opcode 0xA (slti, signed, result 1 or 0) take their source from bits 25:21 and the sign-extended immediate from bits 15:0. They write to the register named in bits 20:16.
- R5: Opcode 0xF (lui) writes the 16-bit immediate into the upper half of the destination register in bits 20:16 and clears the lower half.
- R6: Opcode 0x23 (lw) loads `dmem_rdata` into register bits 20:16. Opcode 0x2B (sw) drives register bits 20:16 on `dmem_wdata` with `dmem_we` high. In both cases the address is the base register in bits 25:21 plus the sign-extended 16-bit displacement. `dmem_we` is high only for sw.
- R7: Opcode 4 (beq) branches when its two source registers are equal, and opcode 5 (bne) branches when they differ. The target is the branch's own address plus the sign-extended immediate times 4. When the branch is not taken, the program counter advances by 4.
- R8: Opcode 2 (j) sets the program counter to the top 4 bits of the current address, then the 26-bit index in bits 25:0, then two zero bits.
- R9: Register 0 reads as zero, and writes to it are discarded.
- R10: Any opcode outside the list above, or any other function code under opcode 0, writes no register and no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the current instruction |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Byte address of a data access |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, sampled on the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr` |

## Verification
Every result is due in the cycle after the instruction is presented. A register write becomes visible to the next instruction that reads it. A store is visible to the bench on the same rising edge that retires it, and a branch or jump shows up as a new `imem_addr` one edge later. Register contents are brought out by programs that store them, so the bench compares a logged sequence of store address and data pairs against an expected table, with the order fixed by program order. The bench drives instructions combinationally, records stores at each rising edge and samples `imem_addr` on the falling edge, so no check depends on the order of processes at a clock edge.

// File: rtl/tiny_core.sv
module tiny_core #(
  parameter int NREG = 32,
  localparam int RW = $clog2(NREG)
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);
  logic [31:0] pc;
  logic [31:0] rf [NREG];
  logic [5:0]  op, fn;
  logic [RW-1:0] rs, rt, rd;
  logic [15:0] imm;
  logic [31:0] simm, rs_val, rt_val, pc4, br_tgt;
  logic        wr_en;
  logic [RW-1:0] wr_idx;
  logic [31:0] wr_val, next_pc;

  assign op  = imem_rdata[31:26];
  assign rs  = imem_rdata[25:21];
  assign rt  = imem_rdata[20:16];
  assign rd  = imem_rdata[15:11];
  assign fn  = imem_rdata[5:0];
  assign imm = imem_rdata[15:0];
  assign simm = {{16{imm[15]}}, imm};

  assign rs_val = (rs == '0) ? '0 : rf[rs];
  assign rt_val = (rt == '0) ? '0 : rf[rt];

  assign pc4    = pc + 32'd4;
  assign br_tgt = pc + {simm[29:0], 2'b00};

  assign imem_addr  = pc;
  assign dmem_addr  = rs_val + simm;
  assign dmem_wdata = rt_val;
  assign dmem_we    = (op == 6'h2B);

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = rt;
    wr_val  = '0;
    next_pc = pc4;
    case (op)
      6'h00: begin
        wr_idx = rd;
        case (fn)
          6'd32: begin wr_en = 1'b1; wr_val = rs_val + rt_val; end
          6'd34: begin wr_en = 1'b1; wr_val = rs_val - rt_val; end
          6'd42: begin wr_en = 1'b1; wr_val = {31'd0, $signed(rs_val) < $signed(rt_val)}; end
          default: ;
        endcase
      end
      6'h08: begin wr_en = 1'b1; wr_val = rs_val + simm; end
      6'h0A: begin wr_en = 1'b1; wr_val = {31'd0, $signed(rs_val) < $signed(simm)}; end
      6'h0F: begin wr_en = 1'b1; wr_val = {imm, 16'd0}; end
      6'h23: begin wr_en = 1'b1; wr_val = dmem_rdata; end
      6'h04: if (rs_val == rt_val) next_pc = br_tgt;
      6'h05: if (rs_val != rt_val) next_pc = br_tgt;
      6'h02: next_pc = {pc[31:28], imem_rdata[25:0], 2'b00};
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= next_pc;
  end

  always_ff @(posedge clk) begin
    if (!rst && wr_en && wr_idx != '0) rf[wr_idx] <= wr_val;
  end
endmodule

// File: rtl/tiny_core_chk.sv
module tiny_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] imem_addr,
  input logic [31:0] imem_rdata,
  input logic        dmem_we,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val
);
  logic [5:0] op;
  logic [31:0] boff;
  logic known;
  assign op   = imem_rdata[31:26];
  assign boff = {{14{imem_rdata[15]}}, imem_rdata[15:0], 2'b00};
  assign known = op inside {6'h00, 6'h02, 6'h04, 6'h05, 6'h08, 6'h0A, 6'h0F, 6'h23, 6'h2B};

  // R1
  reset_pc_chk: assert property (@(posedge clk) rst |=> imem_addr == 32'd0);

  // R2
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    !(op inside {6'h02, 6'h04, 6'h05}) |=> imem_addr == $past(imem_addr) + 32'd4);

  // R6
  store_only_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> op == 6'h2B);

  // R7
  beq_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h04 && rs_val == rt_val) |=> imem_addr == $past(imem_addr) + $past(boff));

  // R7
  bne_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 6'h05 && rs_val == rt_val) |=> imem_addr == $past(imem_addr) + 32'd4);

  // R8
  jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    op == 6'h02 |=> imem_addr == {$past(imem_addr[31:28]), $past(imem_rdata[25:0]), 2'b00});

  // R9
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    imem_rdata[25:21] == 5'd0 |-> rs_val == 32'd0);

  // R10
  unknown_nostore_chk: assert property (@(posedge clk) disable iff (rst)
    !known |-> !dmem_we);
endmodule

bind tiny_core tiny_core_chk u_chk (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
  .dmem_we(dmem_we), .rs_val(rs_val), .rt_val(rt_val)
);

// File: tb/tiny_core_bench.sv
module tiny_core_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic dmem_we;
  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  logic [31:0] log_a [32];
  logic [31:0] log_d [32];
  int n_st = 0;
  int checks = 0;
  int fails = 0;
  bit logging = 1'b1;

  always #4 clk = ~clk;

  tiny_core u_tiny_core (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (!rst && dmem_we) begin
      dmem[dmem_addr[7:2]] <= dmem_wdata;
      if (logging && n_st < 32) begin
        log_a[n_st] <= dmem_addr;
        log_d[n_st] <= dmem_wdata;
        n_st <= n_st + 1;
      end
    end
  end

  function automatic logic [31:0] rt3(input int s, input int t, input int d, input int f);
    return {6'd0, 5'(s), 5'(t), 5'(d), 5'd0, 6'(f)};
  endfunction
  function automatic logic [31:0] it(input int o, input int s, input int t, input int v);
    return {6'(o), 5'(s), 5'(t), 16'(v)};
  endfunction
  function automatic logic [31:0] jt(input int idx);
    return {6'd2, 26'(idx)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  localparam int NEXP = 14;
  localparam logic [63:0] EXP [NEXP] = '{
    {32'd0,  32'h0000_0002},   // R3 add
    {32'd4,  32'hFFFF_FFF8},   // R3 sub
    {32'd8,  32'h0000_0001},   // R3 slt true
    {32'd12, 32'h0000_0000},   // R3 slt false
    {32'd16, 32'h0000_0001},   // R4 slti
    {32'd20, 32'h1234_0000},   // R5 lui
    {32'd24, 32'h0000_0000},   // R9 reg 0
    {32'd60, 32'h0000_0005},   // R6 negative displacement store
    {32'd28, 32'h0000_000A},   // R6 load then add
    {32'd36, 32'hFFFF_FFFD},   // R7 branches, R4 addi negative
    {32'd40, 32'h0000_0006},   // R7 backward bne loop
    {32'd44, 32'h0000_0001},   // R4 slti signed negative
    {32'd48, 32'hFFFF_0000},   // R5 lui high bit
    {32'd52, 32'h0000_0005}    // R10 undecoded ops no write
  };

  initial begin
    for (int i = 0; i < 64; i++) begin imem[i] = jt(i); dmem[i] = '0; end
    imem[0]  = it(8, 0, 1, 5);
    imem[1]  = it(8, 0, 2, -3);
    imem[2]  = rt3(1, 2, 3, 32);
    imem[3]  = rt3(2, 1, 4, 34);
    imem[4]  = rt3(2, 1, 5, 42);
    imem[5]  = rt3(1, 2, 6, 42);
    imem[6]  = it(10, 2, 7, -2);
    imem[7]  = it(15, 0, 8, 'h1234);
    imem[8]  = it(8, 0, 0, 7);
    imem[9]  = it('h2B, 0, 3, 0);
    imem[10] = it('h2B, 0, 4, 4);
    imem[11] = it('h2B, 0, 5, 8);
    imem[12] = it('h2B, 0, 6, 12);
    imem[13] = it('h2B, 0, 7, 16);
    imem[14] = it('h2B, 0, 8, 20);
    imem[15] = it('h2B, 0, 0, 24);
    imem[16] = it(8, 0, 9, 64);
    imem[17] = it('h2B, 9, 1, -4);
    imem[18] = it('h23, 9, 10, -4);
    imem[19] = rt3(10, 10, 11, 32);
    imem[20] = it('h2B, 0, 11, 28);
    imem[21] = it(4, 1, 10, 2);
    imem[22] = it('h2B, 0, 0, 32);
    imem[23] = it(5, 1, 2, 2);
    imem[24] = it('h2B, 0, 1, 32);
    imem[25] = it(4, 1, 2, 2);
    imem[26] = it('h2B, 0, 2, 36);
    imem[27] = it(5, 1, 10, 2);
    imem[28] = jt(31);
    imem[29] = it('h2B, 0, 0, 40);
    imem[30] = it('h2B, 0, 0, 40);
    imem[31] = it(8, 0, 12, 3);
    imem[32] = it(8, 0, 13, 0);
    imem[33] = rt3(13, 12, 13, 32);
    imem[34] = it(8, 12, 12, -1);
    imem[35] = it(5, 12, 0, -2);
    imem[36] = it('h2B, 0, 13, 40);
    imem[37] = it(15, 0, 14, 'hFFFF);
    imem[38] = it(10, 14, 15, 0);
    imem[39] = it('h2B, 0, 15, 44);
    imem[40] = it('h2B, 0, 14, 48);
    imem[41] = rt3(1, 1, 1, 36);
    imem[42] = it(13, 0, 1, 255);
    imem[43] = it('h2B, 0, 1, 52);
    imem[44] = jt(44);

    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R1 reset pc", imem_addr, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 sequential pc", imem_addr, 32'd4);

    repeat (150) @(negedge clk);
    check("R8 halt jump target", imem_addr, 32'd176);
    check("R10 store count", 32'(n_st), 32'(NEXP));
    for (int k = 0; k < NEXP; k++) begin
      check($sformatf("R6 store %0d address", k), log_a[k], EXP[k][63:32]);
      check($sformatf("R3-table store %0d data", k), log_d[k], EXP[k][31:0]);
    end
    check("R7 skipped store slot 32", dmem[8], 32'd0);

    logging = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-run", imem_addr, 32'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 restart advance", imem_addr, 32'd12);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule